// File: doc/BRIEF.md
# CAN Transmit Buffer Request Scheduler

This block sits between software and a CAN bus engine and manages eight message buffers. Each buffer can act as a transmit buffer or a receive buffer, and has its own send request, its own transmit priority and its own auto-reply enable for remote frames. It also keeps three sticky outcome flags: aborted, lost arbitration and bus error. The control bytes of two neighbouring buffers share one 16-bit register. Software changes them through a write port with byte enables and reads them through a combinational read port.

From all transmit buffers with a pending request, the scheduler offers one to the bus engine: the buffer with the highest priority wins, and on a tie the higher buffer index wins. When the engine accepts, the choice is frozen until the engine reports an outcome. The engine reports one of four outcomes: sent, abort done, lost arbitration or bus error. A send that fails keeps its request and competes again. Software cancels a request by writing 0 to its request bit. A buffer that is not on the bus is cancelled on the spot. For the buffer on the bus, the abort is passed to the engine, which confirms it. When a remote frame arrives that matches a buffer with auto-reply enabled, that buffer's request is raised.

Top module: `can_txsched_top`

## Requirements
- R1: After reset every control bit of every buffer is 0, `eng_valid` is 0 and `eng_abort` is 0.
- R2: Buffer 2k lives in bits 7:0 of register k and buffer 2k+1 in bits 15:8. Each byte holds, from bit 7 down: direction (1 = transmit), aborted, lost arbitration, bus error, send request, auto-reply enable, priority[1:0]. A write changes a byte only when its byte-enable bit is set (`wr_be[0]` for bits 7:0). Writes to the three flag bits are ignored.
- R3: Writing 1 to a request bit sets the request and clears the aborted, lost-arbitration and bus-error flags of that buffer.
- R4: An `eng_sent` pulse while busy clears the request of the buffer on the bus and ends the busy period.
- R5: Writing 0 to a set request bit of a buffer that is not on the bus clears the request and sets its aborted flag in the same cycle.
- R6: Writing 0 to the request bit of the buffer on the bus leaves the request at 1 and raises `eng_abort` one cycle later. An `eng_abort_done` pulse then clears the request, sets the aborted flag and drops `eng_abort`.
- R7: While idle, `eng_valid` is 1 exactly when some buffer has direction 1 and request 1. `eng_idx` then names the pending transmit buffer with the highest priority (3 is the highest), and on a tie the highest index. Receive buffers are never offered.
- R8: From the cycle the engine accepts (`eng_valid` and `eng_accept`) until an outcome pulse arrives, `eng_idx` stays on the accepted buffer, even if a buffer that outranks it becomes pending.
- R9: `eng_lost_arb` or `eng_bus_err` while busy sets the matching flag of the buffer on the bus, keeps its request, and ends busy so that selection runs again.
- R10: A `rrx_valid` pulse naming a buffer whose auto-reply bit is 1 sets that buffer's request and clears its three flags. When the auto-reply bit is 0, the buffer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index of the write (buffer pair) |
| wr_be | input | 2 | Byte enables: bit 0 for the even buffer, bit 1 for the odd buffer |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register index of the read |
| rd_data | output | 16 | Contents of the addressed register (combinational) |
| rrx_valid | input | 1 | Remote frame received, one cycle pulse |
| rrx_idx | input | 3 | Buffer matched by the remote frame |
| eng_valid | output | 1 | A transmit buffer is offered to the engine |
| eng_idx | output | 3 | Buffer offered, or the buffer on the bus while busy |
| eng_accept | input | 1 | Engine takes the offered buffer |
| eng_abort | output | 1 | Software asked to abort the buffer on the bus |
| eng_sent | input | 1 | Outcome: message sent |
| eng_abort_done | input | 1 | Outcome: abort carried out |
| eng_lost_arb | input | 1 | Outcome: arbitration lost |
| eng_bus_err | input | 1 | Outcome: bus error |

## Verification
Priority selection is tried in four situations: single pending buffers, priority ties between two transmit buffers (this shows whether the index tie-break goes the right way), a receive buffer holding a high request (this shows whether the direction bit gates selection), and a higher-priority buffer that appears while the engine is busy (this separates frozen selection from live selection). Aborts are driven both on a buffer that is only pending and on the buffer on the bus, which separates the immediate path from the path the engine confirms. Remote frames go to buffers with and without auto-reply. A long random phase then mixes writes, remote frames, accepts and all four outcomes, including same-cycle collisions, and compares every register and engine output each cycle against a bench model.

// File: rtl/can_txsched_pkg.sv
package can_txsched_pkg;

  // Per-buffer control byte, bit 7 down to bit 0.
  typedef struct packed {
    logic       dir;    // 1 = transmit buffer
    logic       abt;    // aborted (sticky, read-only)
    logic       larb;   // lost arbitration (sticky, read-only)
    logic       err;    // bus error (sticky, read-only)
    logic       req;    // send request
    logic       rtr;    // auto-reply to remote frames
    logic [1:0] prio;   // transmit priority, 3 highest
  } bufctl_t;

  localparam int CTL_W = $bits(bufctl_t);

  // Raising a request always wipes the three outcome flags.
  function automatic bufctl_t raise_req(input bufctl_t c);
    bufctl_t r;
    r      = c;
    r.req  = 1'b1;
    r.abt  = 1'b0;
    r.larb = 1'b0;
    r.err  = 1'b0;
    return r;
  endfunction

  // True when candidate a beats candidate b: priority first, index breaks ties.
  function automatic logic outranks(input logic [1:0] pa, input int ia,
                                    input logic [1:0] pb, input int ib);
    return (pa > pb) || ((pa == pb) && (ia > ib));
  endfunction

endpackage

// File: rtl/can_txsched_buf.sv
module can_txsched_buf
  import can_txsched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_hit,
  input  logic [CTL_W-1:0]     wr_byte,
  input  logic                 in_flight,
  input  logic                 ev_sent,
  input  logic                 ev_abd,
  input  logic                 ev_larb,
  input  logic                 ev_err,
  input  logic                 rrx_hit,
  output bufctl_t              ctl,
  output logic                 pend,
  output logic                 abort_req
);

  bufctl_t q, d, wb;
  logic    any_ev;

  always_comb begin
    wb        = bufctl_t'(wr_byte);
    any_ev    = ev_sent | ev_abd | ev_larb | ev_err;
    d         = q;
    abort_req = 1'b0;
    // engine outcome for this buffer
    if (ev_abd) begin
      d.req = 1'b0;
      d.abt = 1'b1;
    end else if (ev_sent) begin
      d.req = 1'b0;
    end else if (ev_err) begin
      d.err = 1'b1;
    end else if (ev_larb) begin
      d.larb = 1'b1;
    end
    // software write: flag bits of the byte are ignored
    if (wr_hit) begin
      d.dir  = wb.dir;
      d.rtr  = wb.rtr;
      d.prio = wb.prio;
      if (wb.req) begin
        d = raise_req(d);
      end else if (d.req) begin
        if (in_flight && !any_ev) begin
          abort_req = 1'b1;          // engine must confirm
        end else begin
          d.req = 1'b0;
          d.abt = 1'b1;
        end
      end
    end
    // remote frame auto-reply
    if (rrx_hit && q.rtr) d = raise_req(d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign ctl  = q;
  assign pend = q.dir & q.req;

  assert_set_clears_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_byte[3]) |=> (ctl.req && !ctl.abt && !ctl.larb && !ctl.err));

  assert_sent_clears_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sent && !ev_abd && !wr_hit && !rrx_hit) |=> !ctl.req);

  assert_idle_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_byte[3] && ctl.req && !in_flight && !any_ev && !rrx_hit)
      |=> (!ctl.req && ctl.abt));

  assert_flight_abort_keeps_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> ctl.req);

  assert_no_reply_keeps_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rrx_hit && !ctl.rtr && !wr_hit && !any_ev) |=> $stable(ctl.req));

endmodule

// File: rtl/can_txsched_arb.sv
module can_txsched_arb
  import can_txsched_pkg::*;
#(
  parameter int NBUF  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBUF-1:0]  pend,
  input  logic [1:0]       prio [NBUF],
  output logic             any_pend,
  output logic [IDX_W-1:0] sel_idx
);

  logic [1:0] best_p;
  int         best_i;

  always_comb begin
    any_pend = 1'b0;
    best_p   = '0;
    best_i   = 0;
    for (int i = 0; i < NBUF; i++) begin
      if (pend[i] && (!any_pend || outranks(prio[i], i, best_p, best_i))) begin
        any_pend = 1'b1;
        best_p   = prio[i];
        best_i   = i;
      end
    end
    sel_idx = IDX_W'(best_i);
  end

  assert_sel_is_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> pend[sel_idx]);

endmodule

// File: rtl/can_txsched_eng.sv
module can_txsched_eng #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_pend,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             eng_accept,
  input  logic             eng_sent,
  input  logic             eng_abort_done,
  input  logic             eng_lost_arb,
  input  logic             eng_bus_err,
  input  logic             abort_hit,
  output logic             eng_valid,
  output logic [IDX_W-1:0] eng_idx,
  output logic             eng_abort,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             start,
  output logic             done
);

  logic             busy_q, abort_q;
  logic [IDX_W-1:0] cur_q;

  assign eng_valid = !busy_q && any_pend;
  assign start     = eng_valid && eng_accept;
  assign done      = busy_q && (eng_sent | eng_abort_done | eng_lost_arb | eng_bus_err);
  assign eng_idx   = busy_q ? cur_q : sel_idx;
  assign eng_abort = abort_q;
  assign busy      = busy_q;
  assign cur_idx   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      if (done)       busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      if (start)      cur_q  <= sel_idx;
      if (done)           abort_q <= 1'b0;
      else if (abort_hit) abort_q <= 1'b1;
    end
  end

  assert_abort_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> busy);

  assert_frozen_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (eng_idx == $past(eng_idx)));

  assert_retry_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (eng_lost_arb || eng_bus_err)) |=> !busy);

endmodule

// File: rtl/can_txsched_top.sv
module can_txsched_top
  import can_txsched_pkg::*;
#(
  parameter int NBUF = 8,
  localparam int IDX_W = $clog2(NBUF),
  localparam int NREG  = NBUF / 2,
  localparam int RA_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [1:0]       wr_be,
  input  logic [15:0]      wr_data,
  input  logic [RA_W-1:0]  rd_addr,
  output logic [15:0]      rd_data,
  input  logic             rrx_valid,
  input  logic [IDX_W-1:0] rrx_idx,
  output logic             eng_valid,
  output logic [IDX_W-1:0] eng_idx,
  input  logic             eng_accept,
  output logic             eng_abort,
  input  logic             eng_sent,
  input  logic             eng_abort_done,
  input  logic             eng_lost_arb,
  input  logic             eng_bus_err
);

  bufctl_t          ctl_a [NBUF];
  logic [1:0]       prio_a [NBUF];
  logic [NBUF-1:0]  pend, abort_v;
  logic             any_pend, busy, start, done, abort_hit;
  logic [IDX_W-1:0] sel_idx, cur_idx;

  assign abort_hit = |abort_v;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    localparam int LANE = i % 2;
    localparam int REG  = i / 2;
    logic mine, wr_hit, in_flight;
    assign mine      = (cur_idx == IDX_W'(i));
    assign wr_hit    = wr_en && (wr_addr == RA_W'(REG)) && wr_be[LANE];
    assign in_flight = (busy && mine) || (start && (sel_idx == IDX_W'(i)));
    assign prio_a[i] = ctl_a[i].prio;

    can_txsched_buf u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit),
      .wr_byte   (wr_data[LANE*CTL_W +: CTL_W]),
      .in_flight (in_flight),
      .ev_sent   (busy && mine && eng_sent),
      .ev_abd    (busy && mine && eng_abort_done),
      .ev_larb   (busy && mine && eng_lost_arb),
      .ev_err    (busy && mine && eng_bus_err),
      .rrx_hit   (rrx_valid && (rrx_idx == IDX_W'(i))),
      .ctl       (ctl_a[i]),
      .pend      (pend[i]),
      .abort_req (abort_v[i])
    );
  end

  can_txsched_arb #(.NBUF(NBUF), .IDX_W(IDX_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .prio     (prio_a),
    .any_pend (any_pend),
    .sel_idx  (sel_idx)
  );

  can_txsched_eng #(.IDX_W(IDX_W)) u_eng (
    .clk            (clk),
    .rst_n          (rst_n),
    .any_pend       (any_pend),
    .sel_idx        (sel_idx),
    .eng_accept     (eng_accept),
    .eng_sent       (eng_sent),
    .eng_abort_done (eng_abort_done),
    .eng_lost_arb   (eng_lost_arb),
    .eng_bus_err    (eng_bus_err),
    .abort_hit      (abort_hit),
    .eng_valid      (eng_valid),
    .eng_idx        (eng_idx),
    .eng_abort      (eng_abort),
    .busy           (busy),
    .cur_idx        (cur_idx),
    .start          (start),
    .done           (done)
  );

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_addr == RA_W'(r)) rd_data = {ctl_a[2*r+1], ctl_a[2*r]};
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!eng_valid || rst_n));

endmodule

// File: tb/tb_can_txsched_top.sv
`timescale 1ns/100ps
module tb_can_txsched_top;
  import can_txsched_pkg::*;

  localparam int NB = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, rrx_valid = 0, eng_accept = 0;
  logic        eng_sent = 0, eng_abort_done = 0, eng_lost_arb = 0, eng_bus_err = 0;
  logic [1:0]  wr_addr = 0, wr_be = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [2:0]  rrx_idx = 0, eng_idx;
  logic        eng_valid, eng_abort;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  bufctl_t m [NB];
  logic    m_busy, m_abp;
  int      m_cur;

  can_txsched_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rrx_valid(rrx_valid), .rrx_idx(rrx_idx), .eng_valid(eng_valid),
    .eng_idx(eng_idx), .eng_accept(eng_accept), .eng_abort(eng_abort),
    .eng_sent(eng_sent), .eng_abort_done(eng_abort_done),
    .eng_lost_arb(eng_lost_arb), .eng_bus_err(eng_bus_err)
  );

  always #4 clk = ~clk;

  // Winner by a single score: priority weighs more than any index.
  function automatic int pick();
    int best = -1, bs = -1;
    for (int b = 0; b < NB; b++) begin
      if (m[b].dir && m[b].req && (int'(m[b].prio) * NB + b) > bs) begin
        bs = int'(m[b].prio) * NB + b;
        best = b;
      end
    end
    return best;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    int s;
    for (int r = 0; r < NB / 2; r++) begin
      rd_addr = 2'(r);
      #0.5;
      chk(tag, $sformatf("reg%0d", r), int'(rd_data), int'({m[2*r+1], m[2*r]}));
    end
    s = pick();
    chk(tag, "eng_valid", int'(eng_valid), int'(!m_busy && s >= 0));
    if (m_busy) chk(tag, "eng_idx busy", int'(eng_idx), m_cur);
    else if (s >= 0) chk(tag, "eng_idx", int'(eng_idx), s);
    chk(tag, "eng_abort", int'(eng_abort), int'(m_abp));
  endtask

  task automatic cyc(input string tag, input logic we, input int wa, input logic [1:0] be,
                     input logic [15:0] wd, input logic rv, input int ri, input logic acc,
                     input logic s, input logic ad, input logic la, input logic er);
    bufctl_t nx [NB];
    bufctl_t wb;
    int sel;
    logic strt, dn, abf;
    wr_en = we; wr_addr = 2'(wa); wr_be = be; wr_data = wd;
    rrx_valid = rv; rrx_idx = 3'(ri); eng_accept = acc;
    eng_sent = s; eng_abort_done = ad; eng_lost_arb = la; eng_bus_err = er;
    sel  = pick();
    strt = !m_busy && sel >= 0 && acc;
    dn   = m_busy && (s || ad || la || er);
    abf  = 1'b0;
    for (int b = 0; b < NB; b++) begin
      logic onbus, fl;
      nx[b] = m[b];
      onbus = m_busy && m_cur == b;
      fl    = onbus || (strt && sel == b);
      if (onbus) begin
        if (ad) begin nx[b].req = 0; nx[b].abt = 1; end
        else if (s) nx[b].req = 0;
        else if (er) nx[b].err = 1;
        else if (la) nx[b].larb = 1;
      end
      if (we && wa == b / 2 && be[b % 2]) begin
        wb = bufctl_t'(wd[8*(b%2) +: 8]);
        nx[b].dir = wb.dir; nx[b].rtr = wb.rtr; nx[b].prio = wb.prio;
        if (wb.req) begin
          nx[b].req = 1; nx[b].abt = 0; nx[b].larb = 0; nx[b].err = 0;
        end else if (nx[b].req) begin
          if (fl && !(onbus && dn)) abf = 1'b1;
          else begin nx[b].req = 0; nx[b].abt = 1; end
        end
      end
      if (rv && ri == b && m[b].rtr) begin
        nx[b].req = 1; nx[b].abt = 0; nx[b].larb = 0; nx[b].err = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rrx_valid = 0; eng_accept = 0;
    eng_sent = 0; eng_abort_done = 0; eng_lost_arb = 0; eng_bus_err = 0;
    for (int b = 0; b < NB; b++) m[b] = nx[b];
    if (dn) m_abp = 0; else if (abf) m_abp = 1;
    if (dn) m_busy = 0;
    else if (strt) begin m_busy = 1; m_cur = sel; end
    chk_all(tag);
  endtask

  task automatic wr(input string tag, input int a, input logic [1:0] be, input logic [15:0] d);
    cyc(tag, 1, a, be, d, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rx(input string tag, input int i);
    cyc(tag, 0, 0, 0, 0, 1, i, 0, 0, 0, 0, 0);
  endtask
  task automatic eng(input string tag, input logic acc, input logic s, input logic ad,
                     input logic la, input logic er);
    cyc(tag, 0, 0, 0, 0, 0, 0, acc, s, ad, la, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    for (int b = 0; b < NB; b++) m[b] = '0;
    m_busy = 0; m_abp = 0; m_cur = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    // layout, byte enables, flag bits ignored
    wr("R2", 0, 2'b01, 16'h00F7);       // buf0: tx, auto-reply, prio3, no req -> 0x87
    wr("R2", 0, 2'b10, 16'h5AFF);       // buf1: receive with req -> 0x0A, low lane untouched
    // selection: receive buffer not offered, tie goes to higher index
    wr("R7", 1, 2'b11, 16'h898A);       // buf2 prio2 req, buf3 prio1 req
    wr("R7", 2, 2'b01, 16'h008A);       // buf4 prio2 req: ties buf2, 4 wins
    chk("R7", "tie winner", int'(eng_idx), 4);
    // freeze while busy
    eng("R8", 1, 0, 0, 0, 0);
    wr("R8", 3, 2'b10, 16'h8B00);       // buf7 prio3 req appears
    chk("R8", "frozen idx", int'(eng_idx), 4);
    // lost arbitration, retry, new winner
    eng("R9", 0, 0, 0, 1, 0);
    chk("R9", "reselect", int'(eng_idx), 7);
    eng("R4", 1, 0, 0, 0, 0);
    eng("R4", 0, 1, 0, 0, 0);
    eng("R9", 1, 0, 0, 0, 0);
    eng("R9", 0, 0, 0, 0, 1);           // bus error on buf4
    wr("R3", 2, 2'b01, 16'h008A);       // re-request buf4 clears flags
    wr("R5", 1, 2'b01, 16'h0080);       // cancel buf2 off the bus
    eng("R6", 1, 0, 0, 0, 0);           // buf4 goes on bus
    wr("R6", 2, 2'b01, 16'h0082);       // cancel buf4 on the bus
    chk("R6", "abort raised", int'(eng_abort), 1);
    eng("R6", 0, 0, 1, 0, 0);
    rx("R10", 0);                       // auto-reply on
    rx("R10", 3);                       // auto-reply off
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      int ev;
      ev = int'($urandom_range(0, 9));
      cyc("R7", ($urandom_range(0, 9) < 3), int'($urandom_range(0, 3)),
          2'($urandom_range(0, 3)), 16'($urandom), ($urandom_range(0, 9) == 0),
          int'($urandom_range(0, 7)), ($urandom_range(0, 1) == 1),
          ev == 0, ev == 1, ev == 2, ev == 3);
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule